// File: doc/BRIEF.md
# Instruction-Class Distance Histogram Monitor

This performance monitor watches a stream of retired instructions, each tagged as a load, a store, a conditional branch or something else. For each of the three tracked classes it measures the gap between consecutive members of that class. The gap is the number of retired instructions that fall strictly between them. The monitor then increments one bin of that class's histogram. The results show how tightly memory references and branches cluster, which helps when sizing store queues, cache ports and branch hardware.

Each class has its own gap counter, an armed flag and sixteen bin counters. Bins 0 to 14 hold exact distances. Bin 15 collects every distance of fifteen or more. A synchronous clear empties all histograms and gap state in one cycle. A registered read port returns any selected bin one cycle after its address is presented.

Top module: `instr_gap_histogram`

## Requirements
- R1: The class code on `ret_class` is 0 for other, 1 for load, 2 for store and 3 for conditional branch. Each of the codes 1 to 3 has its own independent histogram. The read port uses the same code on `rd_class`, and `rd_class` = 0 always reads zero.
- R2: When an instruction of class c retires and class c is armed, bin d of class c is incremented. Here d is the number of valid retirements strictly between it and the previous class-c instruction.
- R3: Two class-c instructions retired back to back, with no valid retirement between them, increment bin 0.
- R4: A distance of 15 or more increments bin 15, the overflow bin. The gap count saturates and does not wrap.
- R5: The first class-c retirement after reset or after clear records nothing and only arms class c.
- R6: Cycles with `ret_valid` low do not add to any distance and change no state, whatever value `ret_class` holds.
- R7: Each bin counter is `CNT_W` bits wide and holds at its all-ones value instead of wrapping.
- R8: `clear` zeroes every bin and disarms every class in one cycle. A retirement in the same cycle as `clear` is discarded.
- R9: `rd_count` shows the bin selected by `rd_class` and `rd_bin` one cycle after they are presented. If an increment or a clear happens in that same cycle, `rd_count` shows the value from before the update.
- R10: After reset, every bin of every class reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of all bins and gap state |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_class | input | 2 | Class of the retiring instruction (0 other, 1 load, 2 store, 3 branch) |
| rd_class | input | 2 | Class selected for reading |
| rd_bin | input | 4 | Bin selected for reading (15 is the overflow bin) |
| rd_count | output | CNT_W | Count of the selected bin, registered |

## Verification
Three activities can land in the same cycle: a read of a bin, an increment of that same bin, and a clear. The bench provokes the read-and-increment case by retiring a second back-to-back load while it reads load bin 0. It expects the value from before the increment, and the new value on the following read. It provokes the clear-and-retire case by asserting `clear` together with a load retirement. It expects all bins to be empty afterwards, and expects the next load to record nothing because that load is the first after the clear. Random traffic then mixes all three activities. The bench compares every read against a model that also captures the bin value before the update.

// File: rtl/instr_gap_histogram.sv
`timescale 1ns/1ps
module instr_gap_histogram #(
  parameter int CNT_W = 32,
  parameter int BIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             ret_valid,
  input  logic [1:0]       ret_class,
  input  logic [1:0]       rd_class,
  input  logic [BIN_W-1:0] rd_bin,
  output logic [CNT_W-1:0] rd_count
);
  localparam int NBINS = 1 << BIN_W;
  localparam logic [BIN_W-1:0] GAP_MAX = BIN_W'(NBINS - 1);

  // entry 0 (class "other") is never written and stays zero
  logic [3:0][NBINS-1:0][CNT_W-1:0] hist_q;
  logic [3:0][BIN_W-1:0]            gap_q;
  logic [3:0]                       armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      gap_q   <= '0;
      armed_q <= '0;
    end else if (clear) begin
      hist_q  <= '0;
      gap_q   <= '0;
      armed_q <= '0;
    end else if (ret_valid) begin
      for (int c = 1; c < 4; c++) begin
        if (ret_class == 2'(c)) begin
          if (armed_q[c] && hist_q[c][gap_q[c]] != '1)
            hist_q[c][gap_q[c]] <= hist_q[c][gap_q[c]] + 1'b1;
          gap_q[c]   <= '0;
          armed_q[c] <= 1'b1;
        end else if (armed_q[c] && gap_q[c] != GAP_MAX) begin
          gap_q[c] <= gap_q[c] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_count <= '0;
    else        rd_count <= hist_q[rd_class][rd_bin];
  end

  assert_other_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_class == 2'd0) |=> (rd_count == '0));

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (armed_q == '0 && gap_q == '0 && hist_q == '0));

  assert_stall_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_valid && !clear) |=> ($stable(hist_q) && $stable(gap_q) && $stable(armed_q)));

  for (genvar g = 1; g < 4; g++) begin : g_cls
    assert_restart_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && !clear && ret_class == 2'(g)) |=> (gap_q[g] == '0 && armed_q[g]));

    assert_first_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && !clear && ret_class == 2'(g) && !armed_q[g]) |=> $stable(hist_q[g]));

    assert_unarmed_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q[g] |-> (gap_q[g] == '0));
  end
endmodule

// File: tb/instr_gap_histogram_tb.sv
`timescale 1ns/1ps
module instr_gap_histogram_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic ret_valid = 1'b0;
  logic [1:0] ret_class = 2'd0;
  logic [1:0] rd_class = 2'd0;
  logic [3:0] rd_bin = 4'd0;
  logic [31:0] rd_count;
  logic [2:0]  rd_count_sat;

  always #4 clk = ~clk;

  instr_gap_histogram #(.CNT_W(32), .BIN_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .clear(clear), .ret_valid(ret_valid),
    .ret_class(ret_class), .rd_class(rd_class), .rd_bin(rd_bin), .rd_count(rd_count));

  instr_gap_histogram #(.CNT_W(3), .BIN_W(4)) dut_sat_i (
    .clk(clk), .rst_n(rst_n), .clear(clear), .ret_valid(ret_valid),
    .ret_class(ret_class), .rd_class(rd_class), .rd_bin(rd_bin), .rd_count(rd_count_sat));

  int checks = 0;
  int errors = 0;
  int m_hist [4][16];
  bit m_arm [4];
  int m_gap [4];

  function automatic void model_reset();
    for (int c = 0; c < 4; c++) begin
      m_arm[c] = 0; m_gap[c] = 0;
      for (int b = 0; b < 16; b++) m_hist[c][b] = 0;
    end
  endfunction

  function automatic void model_step(bit v, bit [1:0] cl, bit clr);
    if (clr) model_reset();
    else if (v) begin
      for (int c = 1; c < 4; c++) begin
        if (cl == 2'(c)) begin
          if (m_arm[c]) m_hist[c][m_gap[c]]++;
          m_gap[c] = 0; m_arm[c] = 1;
        end else if (m_arm[c] && m_gap[c] < 15) m_gap[c]++;
      end
    end
  endfunction

  task automatic step(bit v, bit [1:0] cl, bit clr, bit [1:0] rc, bit [3:0] rb, bit chk, string tag);
    int exp, exps;
    ret_valid = v; ret_class = cl; clear = clr; rd_class = rc; rd_bin = rb;
    exp = m_hist[rc][rb];
    exps = (exp > 7) ? 7 : exp;
    model_step(v, cl, clr);
    @(posedge clk);
    @(negedge clk);
    if (chk) begin
      checks++;
      if (rd_count != 32'(exp)) begin
        errors++;
        $display("FAIL %s class %0d bin %0d: got %0d expected %0d", tag, rc, rb, rd_count, exp);
      end
      checks++;
      if (rd_count_sat != 3'(exps)) begin
        errors++;
        $display("FAIL R7 saturating copy class %0d bin %0d: got %0d expected %0d", rc, rb, rd_count_sat, exps);
      end
    end
  endtask

  task automatic rd(bit [1:0] rc, bit [3:0] rb, string tag);
    step(1'b0, 2'd0, 1'b0, rc, rb, 1'b1, tag);
  endtask

  task automatic ret(bit [1:0] cl);
    step(1'b1, cl, 1'b0, 2'd0, 4'd0, 1'b0, "");
  endtask

  task automatic others(int n);
    for (int i = 0; i < n; i++) ret(2'd0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(2'd1, 4'd0, "R10"); rd(2'd2, 4'd15, "R10"); rd(2'd3, 4'd7, "R10");

    // R5 first load records nothing
    ret(2'd1);
    for (int b = 0; b < 16; b++) rd(2'd1, 4'(b), "R5");

    // R3 back-to-back loads -> bin 0 (read concurrently: R9 pre-update value)
    step(1'b1, 2'd1, 1'b0, 2'd1, 4'd0, 1'b1, "R9");
    rd(2'd1, 4'd0, "R3");

    // R2 / R6 distance 3 with stall cycles carrying load code
    ret(2'd0);
    step(1'b0, 2'd1, 1'b0, 2'd0, 4'd0, 1'b0, "");
    ret(2'd0);
    step(1'b0, 2'd1, 1'b0, 2'd0, 4'd0, 1'b0, "");
    ret(2'd0);
    ret(2'd1);
    rd(2'd1, 4'd3, "R2");
    rd(2'd1, 4'd4, "R6");

    // R4 overflow and exact boundaries on stores
    ret(2'd2); others(14); ret(2'd2);
    rd(2'd2, 4'd14, "R4");
    others(15); ret(2'd2);
    rd(2'd2, 4'd15, "R4");
    others(40); ret(2'd2);
    rd(2'd2, 4'd15, "R4");

    // R1 classes independent, class 0 reads zero
    ret(2'd3); ret(2'd1); ret(2'd3);
    rd(2'd3, 4'd1, "R1");
    rd(2'd1, 4'd1, "R1");
    rd(2'd0, 4'd3, "R1");
    rd(2'd2, 4'd1, "R1");

    // R8 clear together with a retirement, read in the same cycle
    step(1'b1, 2'd1, 1'b1, 2'd1, 4'd0, 1'b1, "R9");
    rd(2'd1, 4'd0, "R8"); rd(2'd2, 4'd15, "R8"); rd(2'd3, 4'd1, "R8");
    ret(2'd1);
    rd(2'd1, 4'd0, "R8");

    // R7 saturation (3-bit copy) with many back-to-back loads
    for (int i = 0; i < 12; i++) ret(2'd1);
    rd(2'd1, 4'd0, "R7");

    // random traffic
    for (int i = 0; i < 5000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      step(r < 75, 2'($urandom_range(0, 3)), $urandom_range(0, 399) == 0,
           2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)), 1'b1, "R2");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule